// File: doc/BRIEF.md
# Framebuffer Mode Geometry Validator

This unit sits between a display controller's mode registers and its scan-out engine. On every clock it takes the programmed mode (an enable word, a colour depth code, the visible width and height, a virtual line width, a horizontal and vertical pan offset), a framebuffer byte-order flag and the size of the video memory in bytes. From these values it derives the pixel format code, the bytes per pixel, the line stride, the byte size of the visible region and the byte address where scan-out starts. It raises `modeValid` only when the whole mode is legal.

All outputs are registered and appear one clock after the inputs. A mode that is illegal clears `modeValid`, but the geometry outputs keep the last mode that was accepted, so downstream logic never sees a half-legal geometry. `modeChanged` is a one-cycle pulse that marks every cycle in which any registered output took a new value. Downstream logic can use it to restart a frame.

Top module: `fbgeom_top`

## Requirements
- R1: While reset is asserted, and until the first accepted mode, `modeValid`, `modeChanged`, `pixFormat`, `bytesPerPixel`, `lineStride`, `regionSize` and `startOffset` are all zero.
- R2: Outputs are registered one clock after the inputs. When bit 0 of `enableWord` is clear, `modeValid` is 0 on the next cycle.
- R3: A depth code of 16 gives `pixFormat` 1 (5-6-5 RGB) and `bytesPerPixel` 2, regardless of the byte-order flag.
- R4: A depth code of 32 gives `bytesPerPixel` 4, with `pixFormat` 2 (x8r8g8b8 little-endian) when `bigEndianFb` is 0 and 3 (x8r8g8b8 big-endian) when it is 1.
- R5: Any depth code other than 16 or 32 makes the mode invalid.
- R6: `lineStride` equals the larger of `virtWidth` and `xRes`, multiplied by the bytes per pixel.
- R7: `regionSize` equals `lineStride` times `yRes`.
- R8: `startOffset` equals `xPan` times bytes per pixel plus `yPan` times `lineStride`.
- R9: The mode is invalid when `xRes` or `yRes` is below MIN_DIM (default 64). A value equal to MIN_DIM is accepted.
- R10: The mode is invalid when `startOffset` + `regionSize` exceeds `vramBytes`. An exact fit is accepted.
- R11: While the mode is invalid, `pixFormat`, `bytesPerPixel`, `lineStride`, `regionSize` and `startOffset` hold the values of the last accepted mode.
- R12: `modeChanged` is 1 for exactly those cycles in which any registered output (including `modeValid`) differs from its value in the cycle before. It is 0 while a mode is held steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enableWord | input | COORD_W | Mode enable word; bit 0 enables the mode |
| depthCode | input | COORD_W | Bits per pixel (16 or 32 are legal) |
| xRes | input | COORD_W | Visible width in pixels |
| yRes | input | COORD_W | Visible height in lines |
| virtWidth | input | COORD_W | Virtual line width in pixels |
| xPan | input | COORD_W | Horizontal pan in pixels |
| yPan | input | COORD_W | Vertical pan in lines |
| bigEndianFb | input | 1 | Framebuffer byte order for 32-bit pixels |
| vramBytes | input | MEM_W | Video memory size in bytes |
| modeValid | output | 1 | Current mode is legal |
| modeChanged | output | 1 | One-cycle pulse when any output changed |
| pixFormat | output | 2 | 0 none, 1 RGB565, 2 XRGB LE, 3 XRGB BE |
| bytesPerPixel | output | 3 | 2 or 4 (0 before first mode) |
| lineStride | output | MEM_W | Bytes per line |
| regionSize | output | MEM_W | Bytes in the visible region |
| startOffset | output | MEM_W | Byte address of the first visible pixel |

## Verification
The hardest cases to reach are the exact edges of legality: a region that ends on the last byte of memory, and a dimension of exactly MIN_DIM. A single change to the memory size or the resolution must switch the result between accepted and rejected. The stimulus drives both sides of each edge in back-to-back cycles. It also changes only the byte-order flag between two otherwise equal modes, to show that a change in format alone raises the change pulse. A long sequence of random modes follows, near the size limits and with mixed depth codes. A reference model in the bench tracks the held geometry and the pulse, and it is compared with the design on every cycle.

// File: rtl/fbgeom_pkg.sv
package fbgeom_pkg;
  typedef enum logic [1:0] {
    FMT_NONE   = 2'd0,
    FMT_RGB565 = 2'd1,
    FMT_XRGBLE = 2'd2,
    FMT_XRGBBE = 2'd3
  } pixFmt_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadGeom;
  } geomStrobe_t;
endpackage

// File: rtl/fbgeom_datapath.sv
module fbgeom_datapath
  import fbgeom_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int MEM_W   = 40,
  parameter int MIN_DIM = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] depthCode,
  input  logic [COORD_W-1:0] xRes,
  input  logic [COORD_W-1:0] yRes,
  input  logic [COORD_W-1:0] virtWidth,
  input  logic [COORD_W-1:0] xPan,
  input  logic [COORD_W-1:0] yPan,
  input  logic               bigEndianFb,
  input  logic [MEM_W-1:0]   vramBytes,
  input  geomStrobe_t        strobe,
  output logic               depthOk,
  output logic               dimOk,
  output logic               fitOk,
  output logic               geomDiffers,
  output pixFmt_t            fmtQ,
  output logic [2:0]         bytesQ,
  output logic [MEM_W-1:0]   strideQ,
  output logic [MEM_W-1:0]   sizeQ,
  output logic [MEM_W-1:0]   offsetQ
);
  localparam logic [COORD_W-1:0] MIN_V = COORD_W'(MIN_DIM);

  pixFmt_t            fmtN;
  logic [2:0]         bytesN;
  logic [COORD_W-1:0] effWidth;
  logic [MEM_W-1:0]   strideN, sizeN, offsetN;
  logic [MEM_W:0]     endAddr;

  always_comb begin
    fmtN    = FMT_NONE;
    bytesN  = 3'd0;
    depthOk = 1'b0;
    if (depthCode == COORD_W'(16)) begin
      fmtN    = FMT_RGB565;
      bytesN  = 3'd2;
      depthOk = 1'b1;
    end else if (depthCode == COORD_W'(32)) begin
      fmtN    = bigEndianFb ? FMT_XRGBBE : FMT_XRGBLE;
      bytesN  = 3'd4;
      depthOk = 1'b1;
    end
  end

  always_comb begin
    effWidth = (virtWidth < xRes) ? xRes : virtWidth;
    strideN  = MEM_W'(effWidth) * MEM_W'(bytesN);
    sizeN    = strideN * MEM_W'(yRes);
    offsetN  = MEM_W'(xPan) * MEM_W'(bytesN) + MEM_W'(yPan) * strideN;
    endAddr  = {1'b0, offsetN} + {1'b0, sizeN};
    dimOk    = (xRes >= MIN_V) && (yRes >= MIN_V);
    fitOk    = endAddr <= {1'b0, vramBytes};
    geomDiffers = (fmtN != fmtQ) || (bytesN != bytesQ) || (strideN != strideQ)
               || (sizeN != sizeQ) || (offsetN != offsetQ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmtQ    <= FMT_NONE;
      bytesQ  <= '0;
      strideQ <= '0;
      sizeQ   <= '0;
      offsetQ <= '0;
    end else if (strobe.loadGeom) begin
      fmtQ    <= fmtN;
      bytesQ  <= bytesN;
      strideQ <= strideN;
      sizeQ   <= sizeN;
      offsetQ <= offsetN;
    end
  end
endmodule

// File: rtl/fbgeom_ctrl.sv
module fbgeom_ctrl
  import fbgeom_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enableBit,
  input  logic        depthOk,
  input  logic        dimOk,
  input  logic        fitOk,
  input  logic        geomDiffers,
  output geomStrobe_t strobe,
  output logic        validQ,
  output logic        changedQ
);
  logic legal;
  logic pulseN;

  always_comb begin
    legal           = enableBit && depthOk && dimOk && fitOk;
    strobe.loadGeom = legal;
    pulseN          = (legal != validQ) || (legal && geomDiffers);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validQ   <= 1'b0;
      changedQ <= 1'b0;
    end else begin
      validQ   <= legal;
      changedQ <= pulseN;
    end
  end
endmodule

// File: rtl/fbgeom_top.sv
module fbgeom_top
  import fbgeom_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int MEM_W   = 40,
  parameter int MIN_DIM = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] enableWord,
  input  logic [COORD_W-1:0] depthCode,
  input  logic [COORD_W-1:0] xRes,
  input  logic [COORD_W-1:0] yRes,
  input  logic [COORD_W-1:0] virtWidth,
  input  logic [COORD_W-1:0] xPan,
  input  logic [COORD_W-1:0] yPan,
  input  logic               bigEndianFb,
  input  logic [MEM_W-1:0]   vramBytes,
  output logic               modeValid,
  output logic               modeChanged,
  output logic [1:0]         pixFormat,
  output logic [2:0]         bytesPerPixel,
  output logic [MEM_W-1:0]   lineStride,
  output logic [MEM_W-1:0]   regionSize,
  output logic [MEM_W-1:0]   startOffset
);
  geomStrobe_t strobe;
  logic        depthOk, dimOk, fitOk, geomDiffers;
  pixFmt_t     fmtQ;

  fbgeom_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .enableBit(enableWord[0]),
    .depthOk(depthOk), .dimOk(dimOk), .fitOk(fitOk), .geomDiffers(geomDiffers),
    .strobe(strobe), .validQ(modeValid), .changedQ(modeChanged)
  );

  fbgeom_datapath #(.COORD_W(COORD_W), .MEM_W(MEM_W), .MIN_DIM(MIN_DIM)) u_dp (
    .clk(clk), .rst_n(rst_n), .depthCode(depthCode), .xRes(xRes), .yRes(yRes),
    .virtWidth(virtWidth), .xPan(xPan), .yPan(yPan), .bigEndianFb(bigEndianFb),
    .vramBytes(vramBytes), .strobe(strobe), .depthOk(depthOk), .dimOk(dimOk),
    .fitOk(fitOk), .geomDiffers(geomDiffers), .fmtQ(fmtQ), .bytesQ(bytesPerPixel),
    .strideQ(lineStride), .sizeQ(regionSize), .offsetQ(startOffset)
  );

  assign pixFormat = fmtQ;
endmodule

// File: rtl/fbgeom_checker.sv
module fbgeom_checker #(
  parameter int COORD_W = 16,
  parameter int MEM_W   = 40,
  parameter int MIN_DIM = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic [COORD_W-1:0] enableWord,
  input logic [COORD_W-1:0] depthCode,
  input logic [COORD_W-1:0] xRes,
  input logic [COORD_W-1:0] yRes,
  input logic [COORD_W-1:0] virtWidth,
  input logic [COORD_W-1:0] xPan,
  input logic [COORD_W-1:0] yPan,
  input logic               bigEndianFb,
  input logic [MEM_W-1:0]   vramBytes,
  input logic               modeValid,
  input logic               modeChanged,
  input logic [1:0]         pixFormat,
  input logic [2:0]         bytesPerPixel,
  input logic [MEM_W-1:0]   lineStride,
  input logic [MEM_W-1:0]   regionSize,
  input logic [MEM_W-1:0]   startOffset
);
  assert_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enableWord[0]) |-> !modeValid);

  assert_format_R3: assert property (@(posedge clk) disable iff (!rst_n)
    modeValid |-> ((pixFormat == 2'd1 && bytesPerPixel == 3'd2) ||
                   (pixFormat >= 2'd2 && bytesPerPixel == 3'd4)));

  assert_depth_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(depthCode) != COORD_W'(16) && $past(depthCode) != COORD_W'(32)) |-> !modeValid);

  assert_min_dim_R9: assert property (@(posedge clk) disable iff (!rst_n)
    modeValid |-> ($past(xRes) >= COORD_W'(MIN_DIM) && $past(yRes) >= COORD_W'(MIN_DIM)));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    modeValid |-> (({1'b0, startOffset} + {1'b0, regionSize}) <= {1'b0, $past(vramBytes)}));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !modeValid |-> ($stable(lineStride) && $stable(regionSize) &&
                    $stable(startOffset) && $stable(pixFormat) && $stable(bytesPerPixel)));

  assert_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    modeChanged == (!$stable(modeValid) || !$stable(pixFormat) || !$stable(bytesPerPixel) ||
                    !$stable(lineStride) || !$stable(regionSize) || !$stable(startOffset)));
endmodule

bind fbgeom_top fbgeom_checker #(.COORD_W(COORD_W), .MEM_W(MEM_W), .MIN_DIM(MIN_DIM)) u_chk (.*);

// File: tb/tb_fbgeom_top.sv
module tb_fbgeom_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int MW = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] enableWord = '0, depthCode = '0, xRes = '0, yRes = '0;
  logic [CW-1:0] virtWidth = '0, xPan = '0, yPan = '0;
  logic bigEndianFb = 1'b0;
  logic [MW-1:0] vramBytes = '0;
  logic modeValid, modeChanged;
  logic [1:0] pixFormat;
  logic [2:0] bytesPerPixel;
  logic [MW-1:0] lineStride, regionSize, startOffset;

  fbgeom_top dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int testsRun = 0, testsFailed = 0;
  string curTag = "R1";

  // Reference model state
  bit mValid = 0, mChg = 0;
  longint mFmt = 0, mBytes = 0, mStride = 0, mSize = 0, mOff = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mValid = 0; mChg = 0; mFmt = 0; mBytes = 0; mStride = 0; mSize = 0; mOff = 0;
    end else begin
      longint f, b, w, s, sz, o;
      bit ok, diff;
      f = 0; b = 0; ok = enableWord[0];
      if (depthCode == 16) begin f = 1; b = 2; end
      else if (depthCode == 32) begin f = bigEndianFb ? 3 : 2; b = 4; end
      else ok = 0;
      w = (virtWidth > xRes) ? virtWidth : xRes;
      s = w * b;
      sz = s * yRes;
      o = xPan * b + yPan * s;
      if (xRes < 64 || yRes < 64) ok = 0;
      if (o + sz > longint'(vramBytes)) ok = 0;
      diff = (f != mFmt) || (b != mBytes) || (s != mStride) || (sz != mSize) || (o != mOff);
      mChg = (ok != mValid) || (ok && diff);
      mValid = ok;
      if (ok) begin mFmt = f; mBytes = b; mStride = s; mSize = sz; mOff = o; end
    end
  end

  always @(negedge clk) begin
    testsRun++;
    if (modeValid !== mValid || modeChanged !== mChg || pixFormat !== 2'(mFmt) ||
        bytesPerPixel !== 3'(mBytes) || lineStride !== MW'(mStride) ||
        regionSize !== MW'(mSize) || startOffset !== MW'(mOff)) begin
      testsFailed++;
      $display("FAIL %s: got v=%0d c=%0d f=%0d b=%0d s=%0d z=%0d o=%0d exp v=%0d c=%0d f=%0d b=%0d s=%0d z=%0d o=%0d",
        curTag, modeValid, modeChanged, pixFormat, bytesPerPixel, lineStride, regionSize,
        startOffset, mValid, mChg, mFmt, mBytes, mStride, mSize, mOff);
    end
  end

  task automatic applyMode(input string tag, input int en, input int bpp, input int x,
                           input int y, input int vw, input int xo, input int yo,
                           input bit be, input longint vram, input int cycles);
    @(negedge clk);
    curTag = tag;
    enableWord = CW'(en); depthCode = CW'(bpp); xRes = CW'(x); yRes = CW'(y);
    virtWidth = CW'(vw); xPan = CW'(xo); yPan = CW'(yo); bigEndianFb = be;
    vramBytes = MW'(vram);
    repeat (cycles - 1) @(negedge clk);
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 16-bit mode, then held steady (R12 no pulse)
    applyMode("R3", 1, 16, 640, 480, 0, 0, 0, 1, 64'd16777216, 3);
    // R4 32-bit little then big endian: only format changes
    applyMode("R4", 1, 32, 640, 480, 0, 0, 0, 0, 64'd16777216, 2);
    applyMode("R4", 1, 32, 640, 480, 0, 0, 0, 1, 64'd16777216, 2);
    // R6 virtual width larger than visible
    applyMode("R6", 1, 32, 640, 480, 1024, 0, 0, 0, 64'd16777216, 2);
    // R7 and R8 pan offsets
    applyMode("R8", 1, 16, 800, 600, 900, 10, 5, 0, 64'd16777216, 2);
    applyMode("R7", 1, 32, 100, 300, 50, 0, 0, 0, 64'd16777216, 2);
    // R5 illegal depth, R11 hold
    applyMode("R5", 1, 24, 640, 480, 0, 0, 0, 0, 64'd16777216, 3);
    applyMode("R11", 1, 8, 320, 200, 0, 0, 0, 0, 64'd16777216, 2);
    // R2 enable bit clear
    applyMode("R2", 2, 32, 640, 480, 0, 0, 0, 0, 64'd16777216, 3);
    // R9 minimum dimension edges
    applyMode("R9", 1, 32, 63, 100, 0, 0, 0, 0, 64'd16777216, 2);
    applyMode("R9", 1, 32, 64, 64, 0, 0, 0, 0, 64'd16777216, 2);
    applyMode("R9", 1, 32, 100, 63, 0, 0, 0, 0, 64'd16777216, 2);
    // R10 exact fit and one byte short
    applyMode("R10", 1, 32, 64, 64, 0, 0, 0, 0, 64'd16384, 2);
    applyMode("R10", 1, 32, 64, 64, 0, 0, 0, 0, 64'd16383, 2);
    applyMode("R10", 1, 32, 64, 64, 0, 1, 0, 0, 64'd16388, 2);
    applyMode("R10", 1, 32, 64, 64, 0, 2, 0, 0, 64'd16388, 2);
    // R12 random sequence
    for (int i = 0; i < 400; i++) begin
      int d;
      longint v;
      d = ($urandom_range(0, 4) == 0) ? 24 : (($urandom_range(0, 1) == 0) ? 16 : 32);
      v = (i % 3 == 0) ? 64'd65536 : 64'd262144;
      applyMode("R12", ($urandom_range(0, 7) == 0) ? 0 : 1, d,
                $urandom_range(60, 200), $urandom_range(60, 200), $urandom_range(0, 300),
                $urandom_range(0, 40), $urandom_range(0, 40), 1'($urandom_range(0, 1)), v,
                $urandom_range(1, 2));
    end
    // R1 reset returns everything to zero
    @(negedge clk);
    curTag = "R1";
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule